// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects 32 external interrupt lines and hands the core one request at a time. Each line has four pieces of configuration and state, all held behind a 32-bit register port: an enable bit, a pending bit, a sense bit that selects pulse or level behaviour, and a 2-bit priority. From the lines that are both enabled and pending, the block picks the most urgent one. It presents that line to the core as an exception number (line + 16) with a request strobe.

The core takes a request by pulsing `req_ack`. That clears the line's pending bit and pushes the line's priority onto a small nesting stack. The top of the stack is the current handler level, shown on `cur_level`. When the handler finishes, the core pulses `req_done`, which pops the stack. A new request is offered only if its priority number is strictly below the current level. The idle level is 4, which is less urgent than any priority that can be configured.

The request side is a two-state machine. In `ST_IDLE` the request is low. The raise transition moves it from `ST_IDLE` to `ST_OFFER` when a candidate can pre-empt. While in `ST_OFFER`, the refresh transition stays in `ST_OFFER` and re-latches the current best candidate each cycle. The taken transition goes back to `ST_IDLE` on acknowledge. The withdraw transition goes back to `ST_IDLE` when no candidate can pre-empt any longer.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Line n (0..31) is presented as exception number n + 16 on `req_num` while `req_valid` is high. The offer appears on the first clock edge after the line becomes enabled and pending, and not before it.
- R2: A write to offset 0x000 sets every enable bit whose data bit is 1. A write to offset 0x080 clears every enable bit whose data bit is 1. Data bits at 0 leave their enable bit unchanged. A read of either offset returns the enable vector, with bit n for line n.
- R3: A write to offset 0x100 sets the pending bits given by the 1s in the data. A write to offset 0x180 clears them. A read of either offset returns the pending vector, with bit n for line n.
- R4: The priority word at offset 0x300 + 4w holds lines 4w to 4w+3. Line 4w+k sits in byte k, bits 8k+7..8k. Only bits 8k+7..8k+6 are stored, and the other bits of each byte read as 0.
- R5: Offset 0x200 holds the sense bits. A 1 in bit n makes line n pulse-sensitive, and a 0 makes it level-sensitive. A read returns the written value.
- R6: A pulse-sensitive line becomes pending on a 0-to-1 change of its input. After its pending bit is cleared, holding the input high does not set the bit again.
- R7: On a level-sensitive line, a high input sets the pending bit at every clock edge. A clear written while the input is high has no lasting effect.
- R8: Among candidates, the lowest priority number wins. On equal priority, the lowest line number wins.
- R9: A line that is pending but not enabled is never offered.
- R10: A candidate is offered only if its priority number is strictly less than `cur_level`. Equal priority does not pre-empt.
- R11: On the edge where `req_ack` is high with `req_valid`, the offered line's pending bit clears and `cur_level` becomes that line's priority. Each `req_done` edge pops one level, and `cur_level` returns to 4 when the stack is empty.
- R12: While a request is being offered, a more urgent candidate that appears replaces the offer one edge later.
- R13: When no candidate can pre-empt any more, `req_valid` falls on the next edge.
- R14: After reset, the enable, pending, sense and priority registers all read 0, `req_valid` is 0 and `cur_level` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | External interrupt lines, one bit per line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| req_valid | output | 1 | A request is being offered to the core |
| req_num | output | 6 | Exception number of the offered line |
| req_ack | input | 1 | Core takes the offered request |
| req_done | input | 1 | Core finishes the innermost handler |
| cur_level | output | 3 | Priority of the running handler, or 4 when idle |

## Verification
A register write takes effect on the edge that samples it, and the new value is visible on `bus_rdata` right after that edge. An input edge or level sets pending on the edge where the input is sampled. The offer on `req_valid`/`req_num` follows one edge after the enable/pending/level condition that supports it, because of the registered offer stage. Acknowledge and done change `cur_level` and pending on their own edge. The bench drives every input on the falling clock edge and samples on a later falling edge. It checks both the cycle before an offer changes (old value still present) and the cycle after (new value present), so a result that arrives one cycle early or late is caught.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } offer_state_t;

    localparam logic [11:0] OFF_EN_SET   = 12'h000;
    localparam logic [11:0] OFF_EN_CLR   = 12'h080;
    localparam logic [11:0] OFF_PEND_SET = 12'h100;
    localparam logic [11:0] OFF_PEND_CLR = 12'h180;
    localparam logic [11:0] OFF_SENSE    = 12'h200;
    localparam logic [11:0] OFF_PRIO     = 12'h300;

    localparam int unsigned EXC_BASE = 16;

endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned PRI_BITS  = 2,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES),
    localparam int unsigned WSEL_W   = IDX_W - 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINES-1:0]            irq_in,
    input  logic                            bus_wr,
    input  logic [11:0]                     bus_addr,
    input  logic [NUM_LINES-1:0]            bus_wdata,
    output logic [NUM_LINES-1:0]            bus_rdata,
    input  logic                            ack_fire,
    input  logic [IDX_W-1:0]                ack_line,
    output logic [NUM_LINES-1:0]            cand,
    output logic [NUM_LINES*PRI_BITS-1:0]   prio_flat
);

    logic [NUM_LINES-1:0] en_q, pend_q, sense_q, irq_q;
    logic [PRI_BITS-1:0]  prio_q [NUM_LINES];

    logic                 prio_hit;
    logic [WSEL_W-1:0]    prio_wsel;
    logic [NUM_LINES-1:0] hw_set, ack_mask, set_mask, clr_mask;

    assign prio_hit  = (bus_addr[11:IDX_W] == OFF_PRIO[11:IDX_W]) && (bus_addr[1:0] == 2'b00);
    assign prio_wsel = bus_addr[IDX_W-1:2];

    // pulse lines: rising edge only; level lines: high input
    assign hw_set   = (sense_q & irq_in & ~irq_q) | (~sense_q & irq_in);
    assign ack_mask = ack_fire ? (NUM_LINES'(1) << ack_line) : '0;
    assign set_mask = (bus_wr && bus_addr == OFF_PEND_SET) ? bus_wdata : '0;
    assign clr_mask = (bus_wr && bus_addr == OFF_PEND_CLR) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            pend_q  <= '0;
            sense_q <= '0;
            irq_q   <= '0;
        end else begin
            irq_q  <= irq_in;
            pend_q <= (pend_q & ~clr_mask & ~ack_mask) | set_mask | hw_set;
            if (bus_wr && bus_addr == OFF_EN_SET) en_q <= en_q | bus_wdata;
            if (bus_wr && bus_addr == OFF_EN_CLR) en_q <= en_q & ~bus_wdata;
            if (bus_wr && bus_addr == OFF_SENSE)  sense_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
        end else if (bus_wr && prio_hit) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (prio_wsel == WSEL_W'(i / 4))
                    prio_q[i] <= bus_wdata[(i % 4) * 8 + 7 -: PRI_BITS];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_EN_SET || bus_addr == OFF_EN_CLR)
            bus_rdata = en_q;
        else if (bus_addr == OFF_PEND_SET || bus_addr == OFF_PEND_CLR)
            bus_rdata = pend_q;
        else if (bus_addr == OFF_SENSE)
            bus_rdata = sense_q;
        else if (prio_hit) begin
            for (int k = 0; k < 4; k++)
                bus_rdata[k * 8 + 7 -: PRI_BITS] = prio_q[{prio_wsel, 2'(k)}];
        end
    end

    assign cand = en_q & pend_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_flat
        assign prio_flat[g * PRI_BITS +: PRI_BITS] = prio_q[g];
    end

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_EN_SET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_EN_CLR) |=> ((en_q & $past(bus_wdata)) == '0));

    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == OFF_EN_SET || bus_addr == OFF_EN_CLR)) |=> $stable(en_q));

    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(~sense_q & irq_in)) == $past(~sense_q & irq_in)));

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned PRI_BITS  = 2,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]          cand,
    input  logic [NUM_LINES*PRI_BITS-1:0] prio_flat,
    output logic                          found,
    output logic [IDX_W-1:0]              best_idx,
    output logic [PRI_BITS-1:0]           best_pri
);

    // scan downwards with <= so the lowest line wins a tie
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_pri = '1;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i] && (!found || prio_flat[i * PRI_BITS +: PRI_BITS] <= best_pri)) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_pri = prio_flat[i * PRI_BITS +: PRI_BITS];
            end
        end
    end

endmodule

// File: rtl/pic_nest.sv
module pic_nest
    import pic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned PRI_BITS  = 2,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES),
    localparam int unsigned NUM_W    = $clog2(EXC_BASE + NUM_LINES),
    localparam int unsigned LVL_W    = PRI_BITS + 1,
    localparam int unsigned DEPTH    = 1 << PRI_BITS,
    localparam int unsigned SP_W     = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                found,
    input  logic [IDX_W-1:0]    best_idx,
    input  logic [PRI_BITS-1:0] best_pri,
    input  logic                req_ack,
    input  logic                req_done,
    output logic                req_valid,
    output logic [NUM_W-1:0]    req_num,
    output logic [LVL_W-1:0]    cur_level,
    output logic                ack_fire,
    output logic [IDX_W-1:0]    ack_line
);

    offer_state_t        state_q, state_d;
    logic [IDX_W-1:0]    req_idx_q;
    logic [PRI_BITS-1:0] req_pri_q;
    logic [PRI_BITS-1:0] stk_q [DEPTH];
    logic [SP_W-1:0]     sp_q;
    logic [PRI_BITS-1:0] top_idx;
    logic                preempt, push, pop;

    assign top_idx   = PRI_BITS'(sp_q - SP_W'(1));
    assign cur_level = (sp_q == '0) ? LVL_W'(DEPTH) : {1'b0, stk_q[top_idx]};
    assign preempt   = found && ({1'b0, best_pri} < cur_level);

    assign req_valid = (state_q == ST_OFFER);
    assign req_num   = NUM_W'(EXC_BASE) + NUM_W'(req_idx_q);
    assign ack_fire  = req_valid && req_ack;
    assign ack_line  = req_idx_q;
    assign push      = ack_fire && (sp_q < SP_W'(DEPTH));
    assign pop       = req_done && !ack_fire && (sp_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (preempt) state_d = ST_OFFER;            // raise
            ST_OFFER: begin
                if (req_ack)       state_d = ST_IDLE;             // taken
                else if (!preempt) state_d = ST_IDLE;             // withdraw
                else               state_d = ST_OFFER;            // refresh
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_idx_q <= '0;
            req_pri_q <= '0;
        end else if (state_d == ST_OFFER) begin
            req_idx_q <= best_idx;
            req_pri_q <= best_pri;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else if (push) begin
            stk_q[sp_q[PRI_BITS-1:0]] <= req_pri_q;
            sp_q <= sp_q + SP_W'(1);
        end else if (pop) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end

    p_num_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_num >= NUM_W'(EXC_BASE) && req_num < NUM_W'(EXC_BASE + NUM_LINES)));

    p_offer_urgent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_pri_q} < cur_level));

    p_nest_strict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q >= SP_W'(2)) |-> (stk_q[top_idx] < stk_q[top_idx - PRI_BITS'(1)]));

    p_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> (sp_q == $past(sp_q) + SP_W'(1)));

    p_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && !ack_fire && sp_q != '0) |=> (sp_q == $past(sp_q) - SP_W'(1)));

    p_withdraw_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack && !preempt) |=> !req_valid);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned PRI_BITS  = 2,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES),
    localparam int unsigned NUM_W    = $clog2(pic_pkg::EXC_BASE + NUM_LINES),
    localparam int unsigned LVL_W    = PRI_BITS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 req_valid,
    output logic [NUM_W-1:0]     req_num,
    input  logic                 req_ack,
    input  logic                 req_done,
    output logic [LVL_W-1:0]     cur_level
);

    logic [NUM_LINES-1:0]          cand;
    logic [NUM_LINES*PRI_BITS-1:0] prio_flat;
    logic                          found, ack_fire;
    logic [IDX_W-1:0]              best_idx, ack_line;
    logic [PRI_BITS-1:0]           best_pri;

    pic_regs #(.NUM_LINES(NUM_LINES), .PRI_BITS(PRI_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_fire(ack_fire), .ack_line(ack_line),
        .cand(cand), .prio_flat(prio_flat)
    );

    pic_arbiter #(.NUM_LINES(NUM_LINES), .PRI_BITS(PRI_BITS)) u_arb (
        .cand(cand), .prio_flat(prio_flat),
        .found(found), .best_idx(best_idx), .best_pri(best_pri)
    );

    pic_nest #(.NUM_LINES(NUM_LINES), .PRI_BITS(PRI_BITS)) u_nest (
        .clk(clk), .rst_n(rst_n),
        .found(found), .best_idx(best_idx), .best_pri(best_pri),
        .req_ack(req_ack), .req_done(req_done),
        .req_valid(req_valid), .req_num(req_num), .cur_level(cur_level),
        .ack_fire(ack_fire), .ack_line(ack_line)
    );

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic [5:0]  req_num;
    logic        req_ack = 1'b0;
    logic        req_done = 1'b0;
    logic [2:0]  cur_level;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_num(req_num),
        .req_ack(req_ack), .req_done(req_done), .cur_level(cur_level)
    );

    // {write, offset, data}; for reads the data is the expected value
    localparam int NV = 19;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 12'h000, 32'h0000_00F0}, {1'b0, 12'h000, 32'h0000_00F0},
        {1'b1, 12'h000, 32'h0000_0003}, {1'b0, 12'h000, 32'h0000_00F3},
        {1'b1, 12'h080, 32'h0000_0030}, {1'b0, 12'h000, 32'h0000_00C3},
        {1'b0, 12'h080, 32'h0000_00C3},
        {1'b1, 12'h100, 32'h8000_0001}, {1'b0, 12'h100, 32'h8000_0001},
        {1'b1, 12'h180, 32'h0000_0001}, {1'b0, 12'h180, 32'h8000_0000},
        {1'b1, 12'h300, 32'hFFFF_FFFF}, {1'b0, 12'h300, 32'hC0C0_C0C0},
        {1'b1, 12'h304, 32'h1234_5678}, {1'b0, 12'h304, 32'h0000_4040},
        {1'b1, 12'h31C, 32'h4080_00C0}, {1'b0, 12'h31C, 32'h4080_00C0},
        {1'b1, 12'h200, 32'h0000_00FF}, {1'b0, 12'h200, 32'h0000_00FF}
    };

    function automatic string vec_tag(input int i);
        if (i < 7)       return "R2";
        else if (i < 11) return "R3";
        else if (i < 17) return "R4";
        else             return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_in = '0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse_ack();
        @(negedge clk); req_ack = 1'b1;
        @(negedge clk); req_ack = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); req_done = 1'b1;
        @(negedge clk); req_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R14: reset state
        rd("R14", 12'h000, 32'h0);
        rd("R14", 12'h100, 32'h0);
        rd("R14", 12'h200, 32'h0);
        rd("R14", 12'h300, 32'h0);
        chk("R14", {31'b0, req_valid}, 32'h0);
        chk("R14", {29'b0, cur_level}, 32'd4);

        // register vectors: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
            else            rd(vec_tag(i), VEC[i][43:32], VEC[i][31:0]);
        end

        // arbitration and nesting
        do_reset();
        wr(12'h304, 32'h0000_8000);   // line 5 -> 2
        wr(12'h308, 32'h0000_C000);   // line 9 -> 3
        wr(12'h30C, 32'h0000_0080);   // line 12 -> 2
        wr(12'h31C, 32'h0040_0000);   // line 30 -> 1
        wr(12'h100, 32'h0000_0020);
        cyc(2);
        chk("R9", {31'b0, req_valid}, 32'h0);
        wr(12'h000, 32'h0000_0020);
        chk("R1", {31'b0, req_valid}, 32'h0);
        cyc(1);
        chk("R1", {31'b0, req_valid}, 32'h1);
        chk("R1", {26'b0, req_num}, 32'd21);
        wr(12'h100, 32'h0000_1200);
        wr(12'h000, 32'h0000_1200);
        cyc(1);
        chk("R8", {26'b0, req_num}, 32'd21);
        wr(12'h000, 32'h4000_0000);
        wr(12'h100, 32'h4000_0000);
        chk("R12", {26'b0, req_num}, 32'd21);
        cyc(1);
        chk("R12", {26'b0, req_num}, 32'd46);

        pulse_ack();
        chk("R11", {29'b0, cur_level}, 32'd1);
        rd("R11", 12'h100, 32'h0000_1220);
        cyc(2);
        chk("R10", {31'b0, req_valid}, 32'h0);
        wr(12'h31C, 32'h4040_0000);   // line 31 -> 1, same as active
        wr(12'h000, 32'h8000_0000);
        wr(12'h100, 32'h8000_0000);
        cyc(2);
        chk("R10", {31'b0, req_valid}, 32'h0);
        wr(12'h000, 32'h0000_0001);
        wr(12'h100, 32'h0000_0001);
        cyc(1);
        chk("R10", {31'b0, req_valid}, 32'h1);
        chk("R8", {26'b0, req_num}, 32'd16);
        pulse_ack();
        chk("R11", {29'b0, cur_level}, 32'd0);
        pulse_done();
        chk("R11", {29'b0, cur_level}, 32'd1);
        pulse_done();
        chk("R11", {29'b0, cur_level}, 32'd4);
        chk("R11", {31'b0, req_valid}, 32'h0);
        cyc(1);
        chk("R8", {26'b0, req_num}, 32'd47);
        wr(12'h080, 32'hFFFF_FFFF);
        chk("R13", {31'b0, req_valid}, 32'h1);
        cyc(1);
        chk("R13", {31'b0, req_valid}, 32'h0);

        // sense behaviour: line 1 level, line 2 pulse
        do_reset();
        wr(12'h200, 32'h0000_0004);
        irq_in[1] = 1'b1;
        cyc(1);
        rd("R7", 12'h100, 32'h0000_0002);
        wr(12'h180, 32'h0000_0002);
        rd("R7", 12'h100, 32'h0000_0002);
        irq_in[1] = 1'b0;
        wr(12'h180, 32'h0000_0002);
        rd("R7", 12'h100, 32'h0000_0000);
        irq_in[2] = 1'b1;
        cyc(1);
        rd("R6", 12'h100, 32'h0000_0004);
        wr(12'h180, 32'h0000_0004);
        cyc(2);
        rd("R6", 12'h100, 32'h0000_0000);
        irq_in[2] = 1'b0;
        cyc(1);
        irq_in[2] = 1'b1;
        cyc(1);
        rd("R6", 12'h100, 32'h0000_0004);

        finish_run();
    end

endmodule